// File: doc/BRIEF.md
# Converter Serial Port With Input-Selection Decode

This block is the device-side serial port of a multiplexed successive-approximation converter. An active-low frame strobe (`frame_n`) opens an exchange. While the strobe is low, the controller clocks `sck`. On rising `sck` edges the block takes a 7-bit setup word from `sdi`. On falling `sck` edges it moves the last conversion result out on `sdo`, most significant bit first.

When a frame closes with the whole setup word received, the word is decoded and registered. The decode gives the positive and negative multiplexer selections, the output coding (unipolar or bipolar) and a sleep request for the analog side. `frame_n`, `sck` and `sdi` are sampled on the system clock `clk`; they are assumed to be synchronous to it already. `sdo` is driven as data plus an enable, and the pad tristate sits outside this block.

Conversion results come in over a valid/ready stream (`res_valid`, `res_ready`, `res_data`):
- `res_ready` is high only while no frame is open.
- A word is taken in any `clk` cycle where both `res_valid` and `res_ready` are high.
- A producer that sees `res_ready` low must hold its word until the frame closes.
- Each taken word is coded with the output coding in force when it is taken. It is then kept and replayed in every later frame until a new word is taken.

Top module: `adc_serial_port`

## Requirements
- R1: The setup word is taken on rising `sck` edges while `frame_n` is low, first bit first. Its bits, in arrival order, are: single-ended select (SE), odd/swap (OS), address high (A1), address low (A0), common-return select (CR), unipolar (UN), sleep (SL). The decoded setup is registered when `frame_n` rises after at least 7 rising `sck` edges.
- R2: With SE=0 the inputs form the pair {A1,A0}. `pos_ch` = {A1,A0,OS} and `neg_ch` = {A1,A0,~OS}, so OS=0 makes the even channel positive and OS=1 swaps the pair. `neg_gnd` is 0.
- R3: With SE=1 and CR=0, `pos_ch` = {A1,A0,OS} and the negative input is ground (`neg_gnd`=1, `neg_ch`=0).
- R4: With SE=1 and CR=1, the negative input is channel 7 (`neg_ch`=7, `neg_gnd`=0). With SE=0 the CR bit has no effect on the selection.
- R5: The code SE=1, CR=1, {A1,A0,OS}=7 is invalid. It yields `pos_ch`=0 against `neg_ch`=7 and sets `sel_err`. Any valid complete frame clears `sel_err`.
- R6: A frame that closes after fewer than 7 rising `sck` edges leaves every decoded output unchanged and sets `cfg_err`. The next complete frame clears `cfg_err`.
- R7: `sdo_oe` is 1 exactly while `frame_n` is low. The result MSB is on `sdo` before the first `sck` edge of a frame.
- R8: Each falling `sck` edge that follows rising edge k of a frame, for k from 1 to RES_W-1, moves the next lower result bit onto `sdo`.
- R9: `sck` edges after the RES_W-th rising edge are ignored. `sdo` keeps showing result bit 0 until the frame closes.
- R10: With UN=1 (`unipolar`=1) a result is sent exactly as received (straight binary). With UN=0 its MSB is inverted, so offset-binary core output is sent as two's complement.
- R11: `res_ready` is low while a frame is open, and a word offered then is not taken. Without a new word, each frame sends the last taken word again.
- R12: SL=1 in a registered setup drives `sleep_req` high, and SL=0 drives it low.
- R13: After reset: `sdo_oe`=0, `pos_ch`=0, `neg_ch`=1, `neg_gnd`=0, `unipolar`=0, `sleep_req`=0, `sel_err`=0, `cfg_err`=0, `res_ready`=1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| frame_n | input | 1 | Active-low frame strobe |
| sck | input | 1 | Serial shift clock |
| sdi | input | 1 | Serial setup data in |
| sdo | output | 1 | Serial result data out |
| sdo_oe | output | 1 | Output enable for the `sdo` pad |
| res_valid | input | 1 | Conversion result offered |
| res_ready | output | 1 | Port can take a result |
| res_data | input | RES_W | Raw offset-binary result from the core |
| pos_ch | output | 3 | Positive multiplexer input |
| neg_ch | output | 3 | Negative multiplexer input when `neg_gnd` is 0 |
| neg_gnd | output | 1 | Negative input is ground |
| unipolar | output | 1 | Unipolar coding selected |
| sleep_req | output | 1 | Sleep requested |
| sel_err | output | 1 | Last setup was the invalid code |
| cfg_err | output | 1 | Last frame was short |

## Verification
The bench goes after the polarity swap and the common-return decode. A decoder that ignored OS, or that honoured CR in pair mode, would select the wrong inputs. It drives the invalid channel-7-against-common code; a design without the remap would short both inputs of the converter to one pin. Short frames are checked for leaving the selection untouched, because a design that commits a partial word would load garbage. Frames with extra `sck` edges are checked for holding bit 0 rather than shifting in zeros. Words offered during a frame are checked as not taken, because a port that overwrote mid-frame would send a mixed word.

// File: rtl/adc_sp_pkg.sv
`timescale 1ns/1ps
package adc_sp_pkg;
  localparam int CFG_BITS = 7;

  // Setup word as it lands in the shift register: first bit at the top.
  typedef struct packed {
    logic       single_end;
    logic       odd_swap;
    logic [1:0] addr;
    logic       com_ret;
    logic       uni;
    logic       sleep;
  } setup_word_t;

  typedef struct packed {
    logic [2:0] pos_ch;
    logic [2:0] neg_ch;
    logic       neg_gnd;
    logic       unipolar;
    logic       sleep_req;
    logic       sel_err;
  } mux_setup_t;

  localparam mux_setup_t SETUP_RST = '{pos_ch: 3'd0, neg_ch: 3'd1, neg_gnd: 1'b0,
                                       unipolar: 1'b0, sleep_req: 1'b0, sel_err: 1'b0};
endpackage

// File: rtl/adc_sp_frame_ctl.sv
`timescale 1ns/1ps
module adc_sp_frame_ctl #(
  parameter int RES_W = 16,
  localparam int CNT_W = $clog2(RES_W + 1)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             frame_n,
  input  logic             sck,
  output logic             rise_evt,
  output logic             fall_evt,
  output logic             frame_end,
  output logic [CNT_W-1:0] bit_cnt
);
  localparam logic [CNT_W-1:0] CNT_MAX = CNT_W'(RES_W);

  logic sck_q;
  logic frame_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sck_q   <= 1'b0;
      frame_q <= 1'b1;
    end else begin
      sck_q   <= sck;
      frame_q <= frame_n;
    end
  end

  assign rise_evt  = !frame_n && sck && !sck_q;
  assign fall_evt  = !frame_n && !sck && sck_q;
  assign frame_end = frame_n && !frame_q;

  // Rising edges seen in this frame, saturating at RES_W.
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                             bit_cnt <= '0;
    else if (frame_end)                     bit_cnt <= '0;
    else if (rise_evt && bit_cnt != CNT_MAX) bit_cnt <= bit_cnt + 1'b1;
  end

  // R9: the edge count never passes the result width
  p_cnt_bound_r9: assert property (@(posedge clk) disable iff (!rst_n)
    bit_cnt <= CNT_MAX);

  // R9: once saturated, further rising edges leave the count alone
  p_cnt_sat_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (bit_cnt == CNT_MAX && !frame_end) |=> bit_cnt == CNT_MAX);
endmodule

// File: rtl/adc_sp_setup_rx.sv
`timescale 1ns/1ps
module adc_sp_setup_rx
  import adc_sp_pkg::*;
#(
  parameter int RES_W = 16,
  localparam int CNT_W = $clog2(RES_W + 1)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             rise_evt,
  input  logic             frame_end,
  input  logic             sdi,
  input  logic [CNT_W-1:0] bit_cnt,
  output setup_word_t      word,
  output logic             commit,
  output logic             short_frame
);
  localparam logic [CNT_W-1:0] WORD_LEN = CNT_W'(CFG_BITS);

  logic [CFG_BITS-1:0] shreg;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                             shreg <= '0;
    else if (rise_evt && bit_cnt < WORD_LEN) shreg <= {shreg[CFG_BITS-2:0], sdi};
  end

  assign word        = setup_word_t'(shreg);
  assign commit      = frame_end && (bit_cnt >= WORD_LEN);
  assign short_frame = frame_end && (bit_cnt <  WORD_LEN);

  // R1: bits after the seventh never disturb the captured word
  p_word_frozen_r1: assert property (@(posedge clk) disable iff (!rst_n)
    (bit_cnt >= WORD_LEN && !frame_end) |=> $stable(shreg));
endmodule

// File: rtl/adc_sp_setup_decode.sv
`timescale 1ns/1ps
module adc_sp_setup_decode
  import adc_sp_pkg::*;
(
  input  setup_word_t word,
  output mux_setup_t  dec
);
  logic [2:0] code;
  assign code = {word.addr, word.odd_swap};

  always_comb begin
    dec           = SETUP_RST;
    dec.pos_ch    = code;
    dec.unipolar  = word.uni;
    dec.sleep_req = word.sleep;
    if (!word.single_end) begin
      dec.neg_ch = {word.addr, ~word.odd_swap};
    end else if (!word.com_ret) begin
      dec.neg_gnd = 1'b1;
      dec.neg_ch  = 3'd0;
    end else begin
      dec.neg_ch = 3'd7;
      if (code == 3'd7) begin
        dec.pos_ch  = 3'd0;
        dec.sel_err = 1'b1;
      end
    end
  end
endmodule

// File: rtl/adc_sp_result_tx.sv
`timescale 1ns/1ps
module adc_sp_result_tx #(
  parameter int RES_W = 16,
  localparam int CNT_W = $clog2(RES_W + 1)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             frame_n,
  input  logic             frame_end,
  input  logic             fall_evt,
  input  logic [CNT_W-1:0] bit_cnt,
  input  logic             unipolar,
  input  logic             res_valid,
  output logic             res_ready,
  input  logic [RES_W-1:0] res_data,
  output logic             sdo
);
  localparam logic [CNT_W-1:0] CNT_MAX = CNT_W'(RES_W);

  logic [RES_W-1:0] held;
  logic [RES_W-1:0] shreg;
  logic [RES_W-1:0] coded;
  logic             accept;

  assign res_ready = frame_n;
  assign accept    = res_valid && res_ready;
  assign coded     = unipolar ? res_data : {~res_data[RES_W-1], res_data[RES_W-2:0]};

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      held  <= '0;
      shreg <= '0;
    end else if (accept) begin
      held  <= coded;
      shreg <= coded;
    end else if (frame_end) begin
      shreg <= held;
    end else if (fall_evt && bit_cnt != '0 && bit_cnt < CNT_MAX) begin
      shreg <= {shreg[RES_W-2:0], 1'b0};
    end
  end

  assign sdo = shreg[RES_W-1];

  // R9: after the last rising edge, falling edges do not move sdo
  p_sdo_hold_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (fall_evt && bit_cnt == CNT_MAX) |=> $stable(sdo));

  // R8: inside a frame the output word moves only on falling edges
  p_quiet_frame_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (!frame_n && !fall_evt) |=> $stable(shreg));

  // R11: the held result cannot change while a frame is open
  p_held_locked_r11: assert property (@(posedge clk) disable iff (!rst_n)
    !frame_n |=> $stable(held));
endmodule

// File: rtl/adc_serial_port.sv
`timescale 1ns/1ps
module adc_serial_port
  import adc_sp_pkg::*;
#(
  parameter int RES_W = 16
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             frame_n,
  input  logic             sck,
  input  logic             sdi,
  output logic             sdo,
  output logic             sdo_oe,
  input  logic             res_valid,
  output logic             res_ready,
  input  logic [RES_W-1:0] res_data,
  output logic [2:0]       pos_ch,
  output logic [2:0]       neg_ch,
  output logic             neg_gnd,
  output logic             unipolar,
  output logic             sleep_req,
  output logic             sel_err,
  output logic             cfg_err
);
  localparam int CNT_W = $clog2(RES_W + 1);

  logic             rise_evt;
  logic             fall_evt;
  logic             frame_end;
  logic [CNT_W-1:0] bit_cnt;
  setup_word_t      word;
  logic             commit;
  logic             short_frame;
  mux_setup_t       dec;
  mux_setup_t       setup_q;

  adc_sp_frame_ctl #(.RES_W(RES_W)) u_frame (
    .clk(clk), .rst_n(rst_n), .frame_n(frame_n), .sck(sck),
    .rise_evt(rise_evt), .fall_evt(fall_evt), .frame_end(frame_end), .bit_cnt(bit_cnt)
  );

  adc_sp_setup_rx #(.RES_W(RES_W)) u_rx (
    .clk(clk), .rst_n(rst_n), .rise_evt(rise_evt), .frame_end(frame_end),
    .sdi(sdi), .bit_cnt(bit_cnt), .word(word), .commit(commit), .short_frame(short_frame)
  );

  adc_sp_setup_decode u_dec (
    .word(word), .dec(dec)
  );

  adc_sp_result_tx #(.RES_W(RES_W)) u_tx (
    .clk(clk), .rst_n(rst_n), .frame_n(frame_n), .frame_end(frame_end),
    .fall_evt(fall_evt), .bit_cnt(bit_cnt), .unipolar(setup_q.unipolar),
    .res_valid(res_valid), .res_ready(res_ready), .res_data(res_data), .sdo(sdo)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      setup_q <= SETUP_RST;
      cfg_err <= 1'b0;
    end else if (commit) begin
      setup_q <= dec;
      cfg_err <= 1'b0;
    end else if (short_frame) begin
      cfg_err <= 1'b1;
    end
  end

  assign sdo_oe    = !frame_n;
  assign pos_ch    = setup_q.pos_ch;
  assign neg_ch    = setup_q.neg_ch;
  assign neg_gnd   = setup_q.neg_gnd;
  assign unipolar  = setup_q.unipolar;
  assign sleep_req = setup_q.sleep_req;
  assign sel_err   = setup_q.sel_err;

  // R6: a short frame leaves the registered selection untouched
  p_short_keeps_r6: assert property (@(posedge clk) disable iff (!rst_n)
    short_frame |=> $stable(setup_q));

  // R5: channel 7 is never selected against itself
  p_no_self_pair_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (!neg_gnd && neg_ch == 3'd7) |-> pos_ch != 3'd7);

  // R1: the selection changes only at the close of a frame
  p_setup_at_close_r1: assert property (@(posedge clk) disable iff (!rst_n)
    !frame_end |=> $stable(setup_q));
endmodule

// File: tb/adc_serial_port_bench.sv
`timescale 1ns/1ps
module adc_serial_port_bench;
  localparam int W = 16;

  logic clk = 1'b0, rst_n = 1'b0, frame_n = 1'b1, sck = 1'b0, sdi = 1'b0, res_valid = 1'b0;
  logic [W-1:0] res_data = '0;
  logic sdo, sdo_oe, res_ready, neg_gnd, unipolar, sleep_req, sel_err, cfg_err;
  logic [2:0] pos_ch, neg_ch;

  int n_chk = 0, n_bad = 0;
  logic cur_uni = 1'b0;
  logic [W-1:0] exp_res = '0;

  adc_serial_port #(.RES_W(W)) u_adc_serial_port (
    .clk(clk), .rst_n(rst_n), .frame_n(frame_n), .sck(sck), .sdi(sdi),
    .sdo(sdo), .sdo_oe(sdo_oe), .res_valid(res_valid), .res_ready(res_ready),
    .res_data(res_data), .pos_ch(pos_ch), .neg_ch(neg_ch), .neg_gnd(neg_gnd),
    .unipolar(unipolar), .sleep_req(sleep_req), .sel_err(sel_err), .cfg_err(cfg_err)
  );

  always #4 clk = ~clk;

  task automatic chk(input string req, input logic [31:0] got, input logic [31:0] exp);
    n_chk++;
    if (got !== exp) begin
      n_bad++;
      $display("FAIL %s: got %h expected %h", req, got, exp);
    end
  endtask

  task automatic clks(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic chk_sel(input string req, input logic [2:0] p, input logic [2:0] n, input logic g);
    chk({req, " pos"}, pos_ch, p);
    chk({req, " neg"}, neg_ch, n);
    chk({req, " gnd"}, neg_gnd, g);
  endtask

  task automatic do_frame(input logic [6:0] word, input int n,
                          output logic [W-1:0] got, output logic last);
    frame_n = 1'b0;
    clks(2);
    chk("R7 oe in frame", sdo_oe, 1'b1);
    got = '0;
    for (int i = 0; i < n; i++) begin
      sdi = (i < 7) ? word[6-i] : 1'b0;
      clks(2);
      if (i < W) got[W-1-i] = sdo;
      sck = 1'b1;
      clks(2);
      sck = 1'b0;
    end
    clks(2);
    last = sdo;
    frame_n = 1'b1;
    clks(3);
    chk("R7 oe idle", sdo_oe, 1'b0);
    if (n >= 7) cur_uni = word[1];
  endtask

  task automatic load(input logic [W-1:0] raw);
    chk("R11 ready idle", res_ready, 1'b1);
    res_data = raw;
    res_valid = 1'b1;
    clks(1);
    res_valid = 1'b0;
    exp_res = cur_uni ? raw : {~raw[W-1], raw[W-2:0]};
  endtask

  task automatic t_reset;
    chk("R13 oe", sdo_oe, 1'b0);
    chk_sel("R13", 3'd0, 3'd1, 1'b0);
    chk("R13 uni", unipolar, 1'b0);
    chk("R13 sleep", sleep_req, 1'b0);
    chk("R13 sel_err", sel_err, 1'b0);
    chk("R13 cfg_err", cfg_err, 1'b0);
    chk("R13 ready", res_ready, 1'b1);
  endtask

  task automatic t_bipolar_read;
    logic [W-1:0] got; logic last;
    load(16'h1234);
    do_frame(7'b0110000, W, got, last);
    chk("R8 R10 bipolar data", got, 16'h9234);
    chk_sel("R2 swap pair", 3'd5, 3'd4, 1'b0);
  endtask

  task automatic t_pair_repeat;
    logic [W-1:0] got; logic last;
    do_frame(7'b0011000, W, got, last);
    chk_sel("R2 even pos", 3'd6, 3'd7, 1'b0);
    chk("R11 repeat", got, exp_res);
  endtask

  task automatic t_single;
    logic [W-1:0] got; logic last;
    do_frame(7'b1101000, W, got, last);
    chk_sel("R3 single gnd", 3'd3, 3'd0, 1'b1);
  endtask

  task automatic t_common;
    logic [W-1:0] got; logic last;
    do_frame(7'b1010100, W, got, last);
    chk_sel("R4 common", 3'd4, 3'd7, 1'b0);
    do_frame(7'b0001100, W, got, last);
    chk_sel("R4 pair ignores CR", 3'd2, 3'd3, 1'b0);
  endtask

  task automatic t_invalid;
    logic [W-1:0] got; logic last;
    do_frame(7'b1111100, W, got, last);
    chk_sel("R5 remap", 3'd0, 3'd7, 1'b0);
    chk("R5 sel_err set", sel_err, 1'b1);
    do_frame(7'b1001000, W, got, last);
    chk("R5 sel_err clear", sel_err, 1'b0);
    chk_sel("R1 order", 3'd2, 3'd0, 1'b1);
  endtask

  task automatic t_short;
    logic [W-1:0] got; logic last;
    do_frame(7'b0111111, 4, got, last);
    chk_sel("R6 kept", 3'd2, 3'd0, 1'b1);
    chk("R6 cfg_err set", cfg_err, 1'b1);
    chk("R6 sleep kept", sleep_req, 1'b0);
    do_frame(7'b1001000, 7, got, last);
    chk("R6 cfg_err clear", cfg_err, 1'b0);
  endtask

  task automatic t_unipolar;
    logic [W-1:0] got; logic last;
    do_frame(7'b0000010, W, got, last);
    chk("R10 uni flag", unipolar, 1'b1);
    load(16'hBEEF);
    do_frame(7'b0000010, W, got, last);
    chk("R10 straight", got, 16'hBEEF);
  endtask

  task automatic t_overrun;
    logic [W-1:0] got; logic last;
    load(16'h0001);
    do_frame(7'b0000010, W + 3, got, last);
    chk("R9 data", got, 16'h0001);
    chk("R9 hold bit0", last, 1'b1);
  endtask

  task automatic t_backpressure;
    logic [W-1:0] got; logic last;
    load(16'h5A5A);
    frame_n = 1'b0;
    clks(1);
    res_data = 16'hFFFF;
    res_valid = 1'b1;
    clks(2);
    chk("R11 ready low", res_ready, 1'b0);
    res_valid = 1'b0;
    frame_n = 1'b1;
    clks(3);
    do_frame(7'b0000010, W, got, last);
    chk("R11 not taken", got, 16'h5A5A);
  endtask

  task automatic t_sleep;
    logic [W-1:0] got; logic last;
    do_frame(7'b0000001, W, got, last);
    chk("R12 sleep", sleep_req, 1'b1);
    load(16'h0000);
    do_frame(7'b0000000, W, got, last);
    chk("R12 wake", sleep_req, 1'b0);
    chk("R10 bipolar zero", got, 16'h8000);
  endtask

  initial begin
    #1600000;
    n_bad++;
    $display("FAIL watchdog: got timeout expected completion");
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end

  initial begin
    clks(3);
    rst_n = 1'b1;
    clks(2);
    t_reset();
    t_bipolar_read();
    t_pair_repeat();
    t_single();
    t_common();
    t_invalid();
    t_short();
    t_unipolar();
    t_overrun();
    t_backpressure();
    t_sleep();
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end
endmodule